// File: doc/BRIEF.md
# Multi-Mode PWM Waveform Timer

A 16-bit timer/counter with three compare channels. A 3-bit mode input selects how it counts, where its TOP value comes from, which points raise the UPDATE and overflow strobes, and what shape of waveform each channel produces. The modes are plain up-counting, frequency generation, single-slope PWM, and three dual-slope PWM variants that differ only in where overflow is flagged.

Each channel keeps a waveform register. A per-channel enable decides whether that waveform or the ordinary port output value reaches the pin. Plain counting makes no waveform, and the unused mode codes behave the same way. The UPDATE strobe marks the point where a surrounding block would load buffered compare values. The overflow strobe is the interrupt source.

Top module: `pwm_wave_timer`

## Requirements
- R1: While `rst_n` is low, `wave` is 0, `ovf` and `upd` are 0, and `pin` equals `port_out` whenever `chan_en` is 0. The counter restarts at 0, counting up.
- R2: While `cnt_en` is 0, the counter holds its value, no `ovf` or `upd` pulse appears, and `wave` does not change.
- R3: Mode 0 counts up from 0 to `period` and wraps to 0. `ovf` and `upd` pulse during the cycle the count equals `period`. `wave` stays 0 and `pin` equals `port_out`. Codes 2 and 4 behave exactly like mode 0.
- R4: Mode 1 counts from 0 up to TOP = compare value 0 and wraps, with `ovf` and `upd` pulsing at TOP. `wave[0]` toggles in the cycle after each TOP. `wave[1]` and `wave[2]` toggle in the cycle after the count equals their own compare value.
- R5: Mode 3 counts from 0 up to `period` and wraps to 0. `ovf` and `upd` pulse together during every cycle in which the count is 0.
- R6: In mode 3, a channel's `wave` goes to 1 in the cycle after the count is 0 and to 0 in the cycle after the count equals its compare value. When both apply, the match wins, so a compare value of 0 gives a constant 0. A compare value above `period` gives a constant 1.
- R7: Modes 5, 6 and 7 count up from 0 to `period`, then down to 0, and repeat. A full cycle is 2×`period` clock cycles.
- R8: In modes 5, 6 and 7, `upd` pulses when the count is 0. `ovf` pulses at TOP (while counting up) in mode 5, at both TOP and 0 in mode 6, and at 0 in mode 7.
- R9: In modes 5, 6 and 7, a channel's `wave` becomes 0 in the cycle after a compare match while counting up, and becomes 1 in the cycle after a match while counting down.
- R10: In modes 1, 3, 5, 6 and 7, `pin[n]` is `wave[n]` when `chan_en[n]` is 1 and `port_out[n]` otherwise. In all other modes, `pin` equals `port_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advances when 1 |
| mode | input | 3 | Mode code (0, 1, 3, 5, 6, 7; 2 and 4 act as 0) |
| period | input | 16 | TOP value in all modes except 1 |
| cmp | input | 48 | Compare values; channel n in bits [16n+15:16n] |
| chan_en | input | 3 | Per-channel enable that routes the waveform to the pin |
| port_out | input | 3 | Ordinary port output value for each pin |
| wave | output | 3 | Channel waveform registers |
| pin | output | 3 | Pin value after the per-channel override |
| ovf | output | 1 | Overflow / interrupt strobe |
| upd | output | 1 | UPDATE strobe |

## Verification
The bench measures where each strobe lands and how far apart consecutive strobes are, for every mode. A design with a wrong TOP source, or with wrap-around off by one, shifts the first pulse or changes the spacing. The dual-slope runs compare codes 5, 6 and 7 against each other, so overflow at the wrong turning point shows up as a wrong pulse count or phase.

For the waveforms, the bench counts high cycles at the edge cases: compare value 0 in single-slope mode (the match must beat BOTTOM), a compare value beyond TOP (the output must stay high), and compare values at 0 and at TOP in dual-slope mode (the output must stay high, or never rise, depending on the counting direction at the match). A design that mishandled any of these would set the wrong level or miss a toggle. A reserved mode code must not produce a waveform, and a disabled count must freeze both the strobes and the counter.

// File: rtl/pwm_wave_timer.sv
module pwm_wave_timer #(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [2:0]        mode,
  input  logic [CW-1:0]     period,
  input  logic [NCH*CW-1:0] cmp,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    port_out,
  output logic [NCH-1:0]    wave,
  output logic [NCH-1:0]    pin,
  output logic              ovf,
  output logic              upd
);
  localparam logic [2:0] M_FRQ = 3'd1;
  localparam logic [2:0] M_SS  = 3'd3;
  localparam logic [2:0] M_DST = 3'd5;
  localparam logic [2:0] M_DSB = 3'd6;
  localparam logic [2:0] M_DBT = 3'd7;

  logic [CW-1:0] cnt, cnt_nxt, top;
  logic          down, down_nxt;

  wire is_frq  = (mode == M_FRQ);
  wire is_ss   = (mode == M_SS);
  wire is_ds   = (mode == M_DST) || (mode == M_DSB) || (mode == M_DBT);
  wire wv_mode = is_frq || is_ss || is_ds;

  assign top = is_frq ? cmp[CW-1:0] : period;

  wire at_top = (cnt >= top);
  wire at_bot = (cnt == '0);
  wire ds_top = at_top && !down;

  always_comb begin
    cnt_nxt  = cnt + CW'(1);
    down_nxt = 1'b0;
    if (is_ds) begin
      if (!down) begin
        if (at_top) begin
          cnt_nxt  = at_bot ? '0 : cnt - CW'(1);
          down_nxt = 1'b1;
        end
      end else if (at_bot) begin
        cnt_nxt  = (top == '0) ? '0 : CW'(1);
        down_nxt = 1'b0;
      end else begin
        cnt_nxt  = cnt - CW'(1);
        down_nxt = 1'b1;
      end
    end else if (at_top) begin
      cnt_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (cnt_en) begin
      cnt  <= cnt_nxt;
      down <= down_nxt;
    end
  end

  logic ovf_raw, upd_raw;
  always_comb begin
    upd_raw = (is_ss || is_ds) ? at_bot : at_top;
    case (mode)
      M_SS:    ovf_raw = at_bot;
      M_DST:   ovf_raw = ds_top;
      M_DSB:   ovf_raw = ds_top || at_bot;
      M_DBT:   ovf_raw = at_bot;
      default: ovf_raw = at_top;
    endcase
  end

  assign ovf = rst_n && cnt_en && ovf_raw;
  assign upd = rst_n && cnt_en && upd_raw;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    wire hit = (cnt == cmp[n*CW +: CW]);
    logic w;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        w <= 1'b0;
      else if (!wv_mode)
        w <= 1'b0;
      else if (cnt_en) begin
        if (is_frq) begin
          if ((n == 0) ? at_top : hit) w <= ~w;
        end else if (is_ss) begin
          if (hit)         w <= 1'b0;
          else if (at_bot) w <= 1'b1;
        end else if (hit) begin
          w <= down;
        end
      end
    end
    assign wave[n] = w;
    assign pin[n]  = (wv_mode && chan_en[n]) ? w : port_out[n];
  end
endmodule

// File: rtl/pwm_wave_timer_chk.sv
module pwm_wave_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [2:0]        mode,
  input logic [CW-1:0]     cnt,
  input logic [NCH*CW-1:0] cmp,
  input logic [NCH-1:0]    chan_en,
  input logic [NCH-1:0]    port_out,
  input logic [NCH-1:0]    wave,
  input logic [NCH-1:0]    pin,
  input logic              ovf,
  input logic              upd
);
  wire no_wv = (mode == 3'd0) || (mode == 3'd2) || (mode == 3'd4);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));

  assert_nowave_R3: assert property (@(posedge clk) disable iff (!rst_n)
    no_wv |=> (wave == '0));

  assert_sstrobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (ovf == upd));

  assert_ssrise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && upd && cmp[CW-1:0] != '0) |=> wave[0]);

  assert_dbot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7) |-> (ovf == upd));

  assert_pinpass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en[0] |-> (pin[0] == port_out[0]));
endmodule

bind pwm_wave_timer pwm_wave_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .cnt(cnt),
  .cmp(cmp), .chan_en(chan_en), .port_out(port_out), .wave(wave),
  .pin(pin), .ovf(ovf), .upd(upd)
);

// File: tb/pwm_wave_timer_tb.sv
module pwm_wave_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] period = 16'd9;
  logic [47:0] cmp = '0;
  logic [2:0]  chan_en = '0;
  logic [2:0]  port_out = '0;
  logic [2:0]  wave, pin;
  logic        ovf, upd;

  int nchk = 0, nerr = 0;
  int n_ovf, n_upd, f_ovf, f_upd, g_ovf, g_upd, l_ovf, l_upd, wchg, pin_err;
  int hi [3];

  always #10 clk = ~clk;

  pwm_wave_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .period(period),
    .cmp(cmp), .chan_en(chan_en), .port_out(port_out), .wave(wave),
    .pin(pin), .ovf(ovf), .upd(upd)
  );

  task automatic check(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic restart(input logic [2:0] m, input logic [15:0] p,
                         input logic [47:0] c, input logic [2:0] ce,
                         input logic [2:0] po, input logic en);
    @(negedge clk);
    rst_n = 1'b0; mode = m; period = p; cmp = c;
    chan_en = ce; port_out = po; cnt_en = en;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic watch(input int n);
    logic [2:0] prev;
    logic       wm;
    n_ovf = 0; n_upd = 0; f_ovf = -1; f_upd = -1; g_ovf = 0; g_upd = 0;
    l_ovf = 0; l_upd = 0; wchg = 0; pin_err = 0;
    for (int c = 0; c < 3; c++) hi[c] = 0;
    #1;
    prev = wave;
    for (int i = 0; i < n; i++) begin
      if (i > 0) #1;
      if (ovf) begin
        if (f_ovf < 0) f_ovf = i; else g_ovf = i - l_ovf;
        l_ovf = i; n_ovf++;
      end
      if (upd) begin
        if (f_upd < 0) f_upd = i; else g_upd = i - l_upd;
        l_upd = i; n_upd++;
      end
      if (wave != prev) wchg++;
      prev = wave;
      wm = (mode == 3'd1) || (mode == 3'd3) || (mode >= 3'd5);
      for (int c = 0; c < 3; c++) begin
        hi[c] += int'(wave[c]);
        if (pin[c] != ((wm && chan_en[c]) ? wave[c] : port_out[c])) pin_err++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; mode = 3'd3; cnt_en = 1'b1; chan_en = 3'b000;
    port_out = 3'b101; cmp = {16'd1, 16'd1, 16'd1};
    @(negedge clk); #1;
    check("R1 wave in reset", int'(wave), 0);
    check("R1 ovf in reset", int'(ovf), 0);
    check("R1 upd in reset", int'(upd), 0);
    check("R1 pin in reset", int'(pin), 5);
  endtask

  task automatic t_normal(input logic [2:0] code);
    restart(code, 16'd9, {16'd2, 16'd5, 16'd3}, 3'b111, 3'b010, 1'b1);
    watch(40);
    check($sformatf("R3 code%0d ovf count", code), n_ovf, 4);
    check($sformatf("R3 code%0d first ovf", code), f_ovf, 9);
    check($sformatf("R3 code%0d ovf gap", code), g_ovf, 10);
    check($sformatf("R3 code%0d first upd", code), f_upd, 9);
    check($sformatf("R3 code%0d upd count", code), n_upd, 4);
    check($sformatf("R3 code%0d wave high", code), hi[0] + hi[1] + hi[2], 0);
    check($sformatf("R3 code%0d pin mismatches", code), pin_err, 0);
  endtask

  task automatic t_freq;
    restart(3'd1, 16'd20, {16'd7, 16'd2, 16'd4}, 3'b011, 3'b100, 1'b1);
    watch(40);
    check("R4 ovf count", n_ovf, 8);
    check("R4 first ovf", f_ovf, 4);
    check("R4 ovf gap", g_ovf, 5);
    check("R4 upd count", n_upd, 8);
    check("R4 wave0 high", hi[0], 20);
    check("R4 wave1 high", hi[1], 20);
    check("R10 freq pin mismatches", pin_err, 0);
  endtask

  task automatic t_hold;
    restart(3'd3, 16'd9, {16'd3, 16'd3, 16'd3}, 3'b111, 3'b000, 1'b0);
    watch(12);
    check("R2 ovf while held", n_ovf, 0);
    check("R2 upd while held", n_upd, 0);
    check("R2 wave changes while held", wchg, 0);
    cnt_en = 1'b1;
    watch(20);
    check("R2 first ovf after release", f_ovf, 0);
    check("R2 ovf count after release", n_ovf, 2);
  endtask

  task automatic t_single;
    restart(3'd3, 16'd9, {16'd12, 16'd0, 16'd3}, 3'b110, 3'b001, 1'b1);
    watch(40);
    check("R5 ovf count", n_ovf, 4);
    check("R5 first ovf", f_ovf, 0);
    check("R5 ovf gap", g_ovf, 10);
    check("R5 upd gap", g_upd, 10);
    check("R6 wave0 high", hi[0], 12);
    check("R6 wave1 high cmp=0", hi[1], 0);
    check("R6 wave2 high cmp>period", hi[2], 39);
    check("R10 single pin mismatches", pin_err, 0);
  endtask

  task automatic t_dual(input logic [2:0] code);
    restart(code, 16'd4, {16'd0, 16'd4, 16'd2}, 3'b101, 3'b010, 1'b1);
    watch(40);
    check($sformatf("R7 code%0d upd count", code), n_upd, 5);
    check($sformatf("R7 code%0d upd gap", code), g_upd, 8);
    check($sformatf("R8 code%0d first upd", code), f_upd, 0);
    case (code)
      3'd5: begin
        check("R8 code5 ovf count", n_ovf, 5);
        check("R8 code5 first ovf", f_ovf, 4);
        check("R8 code5 ovf gap", g_ovf, 8);
      end
      3'd6: begin
        check("R8 code6 ovf count", n_ovf, 10);
        check("R8 code6 first ovf", f_ovf, 0);
        check("R8 code6 ovf gap", g_ovf, 4);
      end
      default: begin
        check("R8 code7 ovf count", n_ovf, 5);
        check("R8 code7 first ovf", f_ovf, 0);
        check("R8 code7 ovf gap", g_ovf, 8);
      end
    endcase
    check($sformatf("R9 code%0d wave0 high", code), hi[0], 17);
    check($sformatf("R9 code%0d wave1 high cmp=top", code), hi[1], 0);
    check($sformatf("R9 code%0d wave2 high cmp=0", code), hi[2], 31);
    check($sformatf("R10 code%0d pin mismatches", code), pin_err, 0);
    #1;
    check($sformatf("R10 code%0d pin1 from port", code), int'(pin[1]), 1);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_normal(3'd0);
    t_normal(3'd2);
    t_normal(3'd4);
    t_freq();
    t_hold();
    t_single();
    t_dual(3'd5);
    t_dual(3'd6);
    t_dual(3'd7);
    finish_run();
  end
endmodule